// File: doc/BRIEF.md
# Mode-0 SPI Byte Engine with Register Echo

This block moves one byte per transfer across a four-wire serial link in SPI mode 0. It drives the serial clock itself once a transfer is started, and it only does so while the active-low chip-select input is held low. Receive data enters on MOSI and is sampled on each rising clock edge. Transmit data leaves on MISO, most significant bit first, and changes only on falling edges. The clock rate comes from a 2-bit rate-select input that picks one of four half-period lengths, counted in system clocks.

Receive and transmit are armed independently. A receive-arm strobe lets the next completed byte be latched and reported with a one-cycle valid pulse. A transmit-arm strobe loads the outgoing byte and lets the end of the transfer be reported with a one-cycle done pulse. With the echo control high, each completed received byte is written into the transmit register, and the following transfer sends it back on MISO. Raising chip select in the middle of a byte abandons that byte without raising any flag.

Top module: `spi_lb_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `sclk`, `miso`, `rx_valid` and `tx_done` are 0 and `rx_data` is 0x00.
- R2: `sclk` is low whenever no transfer is running. In the cycle after any clock edge that samples `cs_n` high, `sclk` is low.
- R3: `freq_sel` value n (0..3) selects a half-period of HALF_n system clocks (parameters). The value is captured when the transfer starts, so every high and every low phase of `sclk` lasts HALF_n cycles, and a full byte holds `sclk` high for 8*HALF_n cycles.
- R4: `mosi` is sampled at each rising `sclk` edge, most significant bit first. If `rx_arm` was pulsed before the byte completed, then in the cycle in which `sclk` is high after the 8th rising edge, `rx_data` shows the byte and `rx_valid` is 1 for exactly that cycle. Without an arm, `rx_valid` stays 0 and `rx_data` keeps its value. Each completion consumes the arm.
- R5: `miso` shows bit 7 of the transmit register from the cycle after the start and moves to the next lower bit only when `sclk` falls. It is stable while `sclk` stays high and is 0 outside a transfer.
- R6: A `tx_arm` pulse while idle loads `tx_data` into the transmit register. A pulse during a transfer is ignored. If armed, `tx_done` pulses for one cycle in the cycle in which `sclk` has returned low after the 8th bit, and the arm is consumed.
- R7: With `loopback` high at the 8th rising edge, the received byte replaces the transmit register, and the next transfer sends it on `miso`.
- R8: Raising `cs_n` during a transfer ends it. `sclk` goes low, no flag is raised, `rx_data` is unchanged, and the bit count starts again from zero on the next start. Arms are kept.
- R9: A `start` pulse while `cs_n` is high is ignored and is not remembered.
- R10: `rx_valid` and `tx_done` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_sel | input | 2 | Rate select for the serial clock |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| start | input | 1 | Begin a transfer (one-cycle strobe) |
| rx_arm | input | 1 | Arm capture and reporting of the next received byte |
| tx_arm | input | 1 | Load `tx_data` and arm the done report |
| tx_data | input | DATA_W | Byte to transmit |
| loopback | input | 1 | Copy each received byte into the transmit register |
| sclk | output | 1 | Serial clock, idles low |
| miso | output | 1 | Serial data out |
| rx_valid | output | 1 | One-cycle pulse: received byte is available |
| rx_data | output | DATA_W | Last latched received byte |
| tx_done | output | 1 | One-cycle pulse: outgoing byte finished |

## Verification
The bench targets the ordering at the end of a byte. If the echo copy or the receive latch were taken one edge late, the design would transmit the previous byte, and a valid pulse placed on the falling edge would arrive with `sclk` already low. A chip-select abort after three bits is checked twice: for leftover bit counts that would make the next byte report early or misaligned, and for a spurious flag. A transmit-arm pulse in the middle of a transfer, a start while deselected, and a transfer without arms exercise the paths where a careless design would overwrite the outgoing byte, start later, or report anyway.

// File: rtl/spi_lb_pkg.sv
package spi_lb_pkg;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_RUN  = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/spi_lb_sclk_gen.sv
module spi_lb_sclk_gen #(
    parameter int unsigned HALF_0 = 1,
    parameter int unsigned HALF_1 = 5,
    parameter int unsigned HALF_2 = 25,
    parameter int unsigned HALF_3 = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] freq_sel,
    output logic       sclk,
    output logic       rise_now,
    output logic       fall_now
);

    localparam int unsigned HMAX01 = (HALF_0 > HALF_1) ? HALF_0 : HALF_1;
    localparam int unsigned HMAX23 = (HALF_2 > HALF_3) ? HALF_2 : HALF_3;
    localparam int unsigned HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
    localparam int unsigned CNT_W  = $clog2(HMAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic [1:0]       sel;
    } gen_t;

    gen_t g_d, g_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        case (g_q.sel)
            2'd0:    half_m1 = CNT_W'(HALF_0 - 1);
            2'd1:    half_m1 = CNT_W'(HALF_1 - 1);
            2'd2:    half_m1 = CNT_W'(HALF_2 - 1);
            default: half_m1 = CNT_W'(HALF_3 - 1);
        endcase
    end

    always_comb begin
        g_d      = g_q;
        rise_now = 1'b0;
        fall_now = 1'b0;
        if (!run) begin
            g_d.cnt  = '0;
            g_d.sclk = 1'b0;
            g_d.sel  = freq_sel;
        end else if (g_q.cnt == half_m1) begin
            g_d.cnt  = '0;
            g_d.sclk = ~g_q.sclk;
            rise_now = ~g_q.sclk;
            fall_now = g_q.sclk;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk = g_q.sclk;

endmodule

// File: rtl/spi_lb_xfer_core.sv
module spi_lb_xfer_core
    import spi_lb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              start,
    input  logic              rx_arm,
    input  logic              tx_arm,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              loopback,
    input  logic              rise_now,
    input  logic              fall_now,
    output logic              run,
    output logic              miso,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_done
);

    localparam int unsigned BIT_W = $clog2(DATA_W + 1);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        xfer_state_e       st;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_data;
        logic [DATA_W-1:0] tx_hold;
        logic              rx_armed;
        logic              tx_armed;
        logic              miso;
        logic              rx_valid;
        logic              tx_done;
    } core_t;

    core_t c_d, c_q;
    logic [DATA_W-1:0] rx_next;
    logic [IDX_W-1:0]  out_idx;

    assign rx_next = {c_q.rx_sh[DATA_W-2:0], mosi};
    assign out_idx = IDX_W'(DATA_W - 1) - IDX_W'(c_q.bits);
    assign run     = (c_q.st == XS_RUN) && !cs_n;

    always_comb begin
        c_d          = c_q;
        c_d.rx_valid = 1'b0;
        c_d.tx_done  = 1'b0;
        if (c_q.st == XS_RUN) begin
            if (cs_n) begin
                c_d.st   = XS_IDLE;
                c_d.bits = '0;
                c_d.miso = 1'b0;
            end else if (rise_now) begin
                c_d.rx_sh = rx_next;
                c_d.bits  = c_q.bits + 1'b1;
                if (c_q.bits == BIT_W'(DATA_W - 1)) begin
                    if (c_q.rx_armed) begin
                        c_d.rx_data  = rx_next;
                        c_d.rx_valid = 1'b1;
                        c_d.rx_armed = 1'b0;
                    end
                    if (loopback) c_d.tx_hold = rx_next;
                end
            end else if (fall_now) begin
                if (c_q.bits == BIT_W'(DATA_W)) begin
                    c_d.st   = XS_IDLE;
                    c_d.bits = '0;
                    c_d.miso = 1'b0;
                    if (c_q.tx_armed) begin
                        c_d.tx_done  = 1'b1;
                        c_d.tx_armed = 1'b0;
                    end
                end else begin
                    c_d.miso = c_q.tx_hold[out_idx];
                end
            end
        end else begin
            if (tx_arm) begin
                c_d.tx_hold  = tx_data;
                c_d.tx_armed = 1'b1;
            end
            if (start && !cs_n) begin
                c_d.st   = XS_RUN;
                c_d.bits = '0;
                c_d.miso = c_d.tx_hold[DATA_W-1];
            end
        end
        if (rx_arm) c_d.rx_armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign miso     = c_q.miso;
    assign rx_valid = c_q.rx_valid;
    assign rx_data  = c_q.rx_data;
    assign tx_done  = c_q.tx_done;

endmodule

// File: rtl/spi_lb_top.sv
module spi_lb_top #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HALF_0 = 1,
    parameter int unsigned HALF_1 = 5,
    parameter int unsigned HALF_2 = 25,
    parameter int unsigned HALF_3 = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        freq_sel,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              start,
    input  logic              rx_arm,
    input  logic              tx_arm,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              loopback,
    output logic              sclk,
    output logic              miso,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_done
);

    logic run;
    logic rise_now;
    logic fall_now;

    spi_lb_sclk_gen #(
        .HALF_0(HALF_0), .HALF_1(HALF_1), .HALF_2(HALF_2), .HALF_3(HALF_3)
    ) u_sclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .freq_sel (freq_sel),
        .sclk     (sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    spi_lb_xfer_core #(
        .DATA_W(DATA_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .start    (start),
        .rx_arm   (rx_arm),
        .tx_arm   (tx_arm),
        .tx_data  (tx_data),
        .loopback (loopback),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .run      (run),
        .miso     (miso),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .tx_done  (tx_done)
    );

endmodule

// File: rtl/spi_lb_checker.sv
module spi_lb_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic miso,
    input logic rx_valid,
    input logic tx_done
);

    // R2: deselect forces the clock low on the next cycle
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sclk);

    // R10: receive flag is a single-cycle pulse
    assert_rv_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: done flag is a single-cycle pulse
    assert_td_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R4: valid appears while the last rising edge still holds sclk high
    assert_rv_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sclk);

    // R6: done appears after sclk has returned low
    assert_td_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !sclk);

    // R5: miso holds while sclk stays high
    assert_miso_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(miso));

    // R8: a deselected cycle raises no flag
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!rx_valid && !tx_done));

endmodule

bind spi_lb_top spi_lb_checker u_spi_lb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .miso     (miso),
    .rx_valid (rx_valid),
    .tx_done  (tx_done)
);

// File: tb/spi_lb_top_bench.sv
`timescale 1ns/1ps
module spi_lb_top_bench;

    localparam int H0 = 1, H1 = 2, H2 = 3, H3 = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_sel = 2'd0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       start = 1'b0;
    logic       rx_arm = 1'b0;
    logic       tx_arm = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       loopback = 1'b0;
    logic       sclk, miso, rx_valid, tx_done;
    logic [7:0] rx_data;

    always #2 clk = ~clk;

    spi_lb_top #(.DATA_W(8), .HALF_0(H0), .HALF_1(H1), .HALF_2(H2), .HALF_3(H3)) u_spi_lb_top (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .cs_n(cs_n), .mosi(mosi),
        .start(start), .rx_arm(rx_arm), .tx_arm(tx_arm), .tx_data(tx_data),
        .loopback(loopback), .sclk(sclk), .miso(miso), .rx_valid(rx_valid),
        .rx_data(rx_data), .tx_done(tx_done)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_run = 0, m_sclk = 0, m_miso = 0, m_rv = 0, m_td = 0, m_rxarm = 0, m_txarm = 0;
    int m_cnt = 0, m_half = 1, m_bits = 0;
    bit [7:0] m_rxsh = 0, m_rxdata = 0, m_tx = 0;
    bit cmp_on = 0;

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0: return H0;
            2'd1: return H1;
            2'd2: return H2;
            default: return H3;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [7:0] b;
        if (!rst_n) begin
            m_run = 0; m_sclk = 0; m_miso = 0; m_rv = 0; m_td = 0;
            m_rxarm = 0; m_txarm = 0; m_cnt = 0; m_bits = 0;
            m_rxsh = 0; m_rxdata = 0; m_tx = 0;
        end else begin
            m_rv = 0; m_td = 0;
            if (m_run) begin
                if (cs_n) begin
                    m_run = 0; m_sclk = 0; m_cnt = 0; m_bits = 0; m_miso = 0;
                end else if (m_cnt == m_half - 1) begin
                    m_cnt = 0;
                    if (!m_sclk) begin
                        m_sclk = 1;
                        b = {m_rxsh[6:0], mosi};
                        m_rxsh = b;
                        m_bits++;
                        if (m_bits == 8) begin
                            if (m_rxarm) begin m_rxdata = b; m_rv = 1; m_rxarm = 0; end
                            if (loopback) m_tx = b;
                        end
                    end else begin
                        m_sclk = 0;
                        if (m_bits == 8) begin
                            m_run = 0; m_bits = 0; m_miso = 0;
                            if (m_txarm) begin m_td = 1; m_txarm = 0; end
                        end else m_miso = m_tx[7 - m_bits];
                    end
                end else m_cnt++;
            end else begin
                if (tx_arm) begin m_tx = tx_data; m_txarm = 1; end
                if (start && !cs_n) begin
                    m_run = 1; m_cnt = 0; m_sclk = 0; m_bits = 0;
                    m_half = half_of(freq_sel); m_miso = m_tx[7];
                end
            end
            if (rx_arm) m_rxarm = 1;
        end
    end

    // monitor, per-clock comparison and mosi driver, 1 ns after the edge
    bit [7:0] mosi_byte = 0;
    bit       xfer_on = 0;
    bit       prev_sclk = 0;
    int       rv_cnt = 0, td_cnt = 0, high_cnt = 0, rise_cnt = 0;
    bit [7:0] miso_cap = 0;

    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            check("R3 sclk vs model", sclk, m_sclk);
            check("R5 miso vs model", miso, m_miso);
            check("R4 rx_valid vs model", rx_valid, m_rv);
            check("R4 rx_data vs model", rx_data, m_rxdata);
            check("R6 tx_done vs model", tx_done, m_td);
        end
        if (rx_valid) rv_cnt++;
        if (tx_done) td_cnt++;
        if (sclk) high_cnt++;
        if (sclk && !prev_sclk) begin
            rise_cnt++;
            miso_cap = {miso_cap[6:0], miso};
        end
        prev_sclk = sclk;
        if (xfer_on && m_bits < 8) mosi = mosi_byte[7 - m_bits];
    end

    task automatic xfer(input logic [1:0] sel, input bit [7:0] mb, input bit arx,
                        input bit atx, input bit [7:0] tb, input bit mid);
        @(negedge clk);
        freq_sel = sel; mosi_byte = mb; tx_data = tb;
        rx_arm = arx; tx_arm = atx; start = 1'b1; xfer_on = 1;
        rv_cnt = 0; td_cnt = 0; high_cnt = 0; rise_cnt = 0; miso_cap = 0;
        @(negedge clk);
        rx_arm = 0; tx_arm = 0; start = 0;
        if (mid) begin
            while (rise_cnt < 4) @(negedge clk);
            tx_data = 8'hFF; tx_arm = 1'b1;
            @(negedge clk);
            tx_arm = 1'b0;
        end
        while (m_run) @(negedge clk);
        repeat (3) @(negedge clk);
        xfer_on = 0;
    endtask

    task automatic run_tests();
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sclk in reset", sclk, 0);
        check("R1 miso in reset", miso, 0);
        check("R1 rx_valid in reset", rx_valid, 0);
        check("R1 tx_done in reset", tx_done, 0);
        check("R1 rx_data in reset", rx_data, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        check("R1 sclk after reset", sclk, 0);
        check("R1 rx_data after reset", rx_data, 0);

        // R9/R2: start while deselected is ignored and not remembered
        cs_n = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        high_cnt = 0;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 no clock after ignored start", high_cnt, 0);
        check("R2 sclk idle low", sclk, 0);

        // R4/R5/R6/R10: basic armed transfer at fastest rate
        xfer(2'd0, 8'h3C, 1, 1, 8'hA5, 0);
        check("R4 rx_data captured", rx_data, 8'h3C);
        check("R5 miso bits", miso_cap, 8'hA5);
        check("R10 one rx_valid", rv_cnt, 1);
        check("R6 one tx_done", td_cnt, 1);
        check("R3 high cycles sel0", high_cnt, 8 * H0);

        // R3: rate captured at start, slower setting
        xfer(2'd2, 8'hC3, 1, 1, 8'h5A, 0);
        check("R3 high cycles sel2", high_cnt, 8 * H2);
        check("R4 rx_data sel2", rx_data, 8'hC3);
        check("R5 miso bits sel2", miso_cap, 8'h5A);

        // R7: echo the received byte into the transmit register
        loopback = 1'b1;
        xfer(2'd1, 8'h96, 1, 1, 8'h00, 0);
        loopback = 1'b0;
        check("R5 miso before echo", miso_cap, 8'h00);
        xfer(2'd1, 8'h11, 0, 0, 8'h00, 0);
        check("R7 echoed byte on miso", miso_cap, 8'h96);
        check("R4 unarmed rx_valid absent", rv_cnt, 0);
        check("R4 unarmed rx_data kept", rx_data, 8'h96);
        check("R6 unarmed tx_done absent", td_cnt, 0);

        // R6: tx_arm during a transfer is ignored
        xfer(2'd3, 8'h01, 0, 1, 8'h6B, 1);
        check("R6 miso of armed byte", miso_cap, 8'h6B);
        xfer(2'd0, 8'h02, 0, 0, 8'h00, 0);
        check("R6 mid-transfer arm ignored", miso_cap, 8'h6B);
        check("R6 no done after ignored arm", td_cnt, 0);

        // R8: abort mid-byte, then a clean byte
        @(negedge clk);
        freq_sel = 2'd1; mosi_byte = 8'hE7; rx_arm = 1'b1; tx_data = 8'h81; tx_arm = 1'b1;
        start = 1'b1; xfer_on = 1;
        rv_cnt = 0; td_cnt = 0; rise_cnt = 0;
        @(negedge clk);
        rx_arm = 0; tx_arm = 0; start = 0;
        while (rise_cnt < 3) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 sclk low after abort", sclk, 0);
        repeat (4) @(negedge clk);
        check("R8 no rx_valid on abort", rv_cnt, 0);
        check("R8 no tx_done on abort", td_cnt, 0);
        check("R8 rx_data unchanged", rx_data, 8'h96);
        xfer_on = 0;
        cs_n = 1'b0;
        xfer(2'd1, 8'h4D, 0, 0, 8'h00, 0);
        check("R8 full byte after abort", rx_data, 8'h4D);
        check("R8 kept rx arm reports once", rv_cnt, 1);
        check("R8 kept tx arm reports once", td_cnt, 1);
        check("R8 miso after abort restarts at MSB", miso_cap, 8'h81);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule